// File: doc/BRIEF.md
# Multi-Word Register Loader

This block performs a block load of consecutive 32-bit words into the tail of a 32-entry, 64-bit register file. It receives a one-cycle start pulse together with the first destination register index, the number and value of a base register, and a 16-bit signed displacement. The first memory address is the base value plus the sign-extended displacement. When the base register number is zero, the base value is taken as zero.

From that address the loader reads one 4-byte word at a time over a valid/ready request channel and a valid/ready response channel. It writes each word, zero-extended to 64 bits, into the next register. The walk stops after register 31 is written. A one-cycle done pulse then returns the block to idle.

Back-pressure rules: once a request is presented, valid and address hold until the memory asserts ready, and only one request is ever in flight. The response channel is ready only while that one request is outstanding. The register write happens in the cycle after the response handshake. The next request is presented only after that write.

Top module: `multiword_loader`

## Requirements
- R1: After reset the block is idle: busy, done, mem_req_valid, mem_rsp_ready and rf_we are all low.
- R2: The cycle after a start is accepted in idle, a request is presented whose address is the base value plus the sign-extended displacement. A base register number of 0 makes the base value read as zero.
- R3: Every later request address equals the previous request address plus 4.
- R4: Register writes use consecutive indices from the starting index up to and including 31, one write per word, then stop. A start at index k makes exactly 32-k writes.
- R5: Each write carries the returned 32-bit word in bits 31:0 and zeros in bits 63:32, also when bit 31 of the word is set.
- R6: After a request handshake no further request is presented until the register write of its response has happened.
- R7: While mem_req_valid is high and mem_req_ready is low, the request stays valid and its address does not change.
- R8: busy is high from the cycle after an accepted start until the block is idle again. Start pulses while busy are ignored and change neither the indices nor the addresses of the running sequence.
- R9: A start with starting index 31 performs exactly one request and one register write.
- R10: done is high for exactly one cycle, the cycle right after the write to register 31. busy is low in the cycle after done.
- R11: mem_rsp_ready is high only while a request is outstanding, and the register write follows in the cycle after the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse, accepted only while idle |
| start_idx | input | 5 | First destination register index |
| base_idx | input | 5 | Base register number; 0 selects a zero base |
| base_val | input | 64 | Value of the base register |
| disp | input | 16 | Signed byte displacement |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Loader accepts read data |
| mem_rsp_data | input | 32 | Returned word |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 5 | Register write index |
| rf_data | output | 64 | Zero-extended register write data |

## Verification
A corrupted index counter shows at the register port on the very next write, as a skipped or repeated index or a wrong write count before done. A corrupted address register shows on the next request handshake, as an address that is not the previous one plus 4, and it also shows as wrong data because the memory model returns a value derived from the address. A control state that slips shows within one or two cycles, as a second request in flight, a request dropped under back-pressure, response ready with nothing outstanding, or a done pulse that does not directly follow the write to register 31.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

  typedef enum logic [2:0] {
    MWL_IDLE  = 3'd0,
    MWL_ISSUE = 3'd1,
    MWL_AWAIT = 3'd2,
    MWL_WRITE = 3'd3,
    MWL_FIN   = 3'd4
  } mwl_state_t;

endpackage

// File: rtl/mwl_addr_unit.sv
module mwl_addr_unit #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] addr_q;

  // base register number zero stands for a literal zero base
  assign base_eff   = (base_idx == '0) ? '0 : base_val;
  assign disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign first_addr = base_eff + disp_ext;

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (load)    addr_q <= first_addr;
    else if (advance) addr_q <= addr_q + ADDR_W'(STEP);
  end

  assign addr = addr_q;
endmodule

// File: rtl/mwl_index_counter.sv
module mwl_index_counter #(
  parameter int NREG  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [IDX_W-1:0] first_idx,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (load)    idx_q <= first_idx;
    else if (advance) idx_q <= idx_q + 1'b1;
  end

  assign idx     = idx_q;
  assign at_last = (idx_q == LAST_IDX);
endmodule

// File: rtl/mwl_word_buffer.sv
module mwl_word_buffer #(
  parameter int WORD_W = 32,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WORD_W-1:0] word_in,
  output logic [REG_W-1:0]  reg_out
);
  localparam int PAD_W = REG_W - WORD_W;

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= '0;
    else if (capture) word_q <= word_in;
  end

  // upper bits are filled with zeros, never with the word's top bit
  assign reg_out = {{PAD_W{1'b0}}, word_q};
endmodule

// File: rtl/mwl_control.sv
module mwl_control
  import mwl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic at_last,
  output logic load,
  output logic advance,
  output logic capture,
  output logic req_valid,
  output logic rsp_ready,
  output logic wr_en,
  output logic busy,
  output logic done
);
  mwl_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= MWL_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    advance = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      MWL_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = MWL_ISSUE;
        end
      end
      MWL_ISSUE: begin
        if (req_ready) state_d = MWL_AWAIT;
      end
      MWL_AWAIT: begin
        if (rsp_valid) begin
          capture = 1'b1;
          state_d = MWL_WRITE;
        end
      end
      MWL_WRITE: begin
        if (at_last) begin
          state_d = MWL_FIN;
        end else begin
          advance = 1'b1;
          state_d = MWL_ISSUE;
        end
      end
      MWL_FIN:  state_d = MWL_IDLE;
      default:  state_d = MWL_IDLE;
    endcase
  end

  assign req_valid = (state_q == MWL_ISSUE);
  assign rsp_ready = (state_q == MWL_AWAIT);
  assign wr_en     = (state_q == MWL_WRITE);
  assign done      = (state_q == MWL_FIN);
  assign busy      = (state_q != MWL_IDLE);
endmodule

// File: rtl/multiword_loader.sv
module multiword_loader #(
  parameter int NREG   = 32,
  parameter int REG_W  = 64,
  parameter int WORD_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [REG_W-1:0]  base_val,
  input  logic [DISP_W-1:0] disp,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [REG_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [REG_W-1:0]  rf_data
);
  localparam int WORD_BYTES = WORD_W / 8;

  logic load, advance, capture, at_last;

  mwl_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .at_last   (at_last),
    .load      (load),
    .advance   (advance),
    .capture   (capture),
    .req_valid (mem_req_valid),
    .rsp_ready (mem_rsp_ready),
    .wr_en     (rf_we),
    .busy      (busy),
    .done      (done)
  );

  mwl_addr_unit #(
    .ADDR_W (REG_W),
    .DISP_W (DISP_W),
    .IDX_W  (IDX_W),
    .STEP   (WORD_BYTES)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .advance  (advance),
    .base_idx (base_idx),
    .base_val (base_val),
    .disp     (disp),
    .addr     (mem_req_addr)
  );

  mwl_index_counter #(
    .NREG  (NREG),
    .IDX_W (IDX_W)
  ) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .advance   (advance),
    .first_idx (start_idx),
    .idx       (rf_idx),
    .at_last   (at_last)
  );

  mwl_word_buffer #(
    .WORD_W (WORD_W),
    .REG_W  (REG_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .word_in (mem_rsp_data),
    .reg_out (rf_data)
  );
endmodule

// File: rtl/mwl_checker.sv
module mwl_checker #(
  parameter int NREG   = 32,
  parameter int REG_W  = 64,
  parameter int WORD_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [IDX_W-1:0]  base_idx,
  input logic [REG_W-1:0]  base_val,
  input logic [DISP_W-1:0] disp,
  input logic              busy,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [REG_W-1:0]  mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic [WORD_W-1:0] mem_rsp_data,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_idx,
  input logic [REG_W-1:0]  rf_data
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);
  localparam int PAD_W = REG_W - WORD_W;

  logic             accept, req_fire, rsp_fire;
  logic             have_idx, have_addr;
  logic [IDX_W-1:0] prev_idx;
  logic [REG_W-1:0] prev_addr;

  assign accept   = start && !busy;
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || accept) begin
      have_idx  <= 1'b0;
      have_addr <= 1'b0;
      prev_idx  <= '0;
      prev_addr <= '0;
    end else begin
      if (rf_we)    begin have_idx  <= 1'b1; prev_idx  <= rf_idx;       end
      if (req_fire) begin have_addr <= 1'b1; prev_addr <= mem_req_addr; end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mem_rsp_ready && !rf_we && !done);

  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req_valid && mem_req_addr ==
      (($past(base_idx) == '0) ? '0 : $past(base_val)) +
      {{(REG_W-DISP_W){$past(disp[DISP_W-1])}}, $past(disp)});

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && have_addr |-> mem_req_addr == prev_addr + REG_W'(WORD_W/8));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && have_idx |-> rf_idx == prev_idx + 1'b1);

  a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> rf_we && rf_data == {{PAD_W{1'b0}}, $past(mem_rsp_data)});

  a_r6_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r8_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_idx == TOP_IDX |=> done);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r11_rsp_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid && !rf_we);
endmodule

bind multiword_loader mwl_checker #(
  .NREG   (NREG),
  .REG_W  (REG_W),
  .WORD_W (WORD_W),
  .DISP_W (DISP_W),
  .IDX_W  (IDX_W)
) u_mwl_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .base_idx      (base_idx),
  .base_val      (base_val),
  .disp          (disp),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .mem_rsp_data  (mem_rsp_data),
  .rf_we         (rf_we),
  .rf_idx        (rf_idx),
  .rf_data       (rf_data)
);

// File: tb/multiword_loader_test.sv
module multiword_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  start_idx = '0;
  logic [4:0]  base_idx = '0;
  logic [63:0] base_val = '0;
  logic [15:0] disp = '0;
  logic        busy, done;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;

  multiword_loader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .base_idx(base_idx), .base_val(base_val), .disp(disp),
    .busy(busy), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return (a[31:0] * 32'h9E37_79B1) ^ {a[47:32], a[15:0]} ^ 32'h8000_0000;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-operation expectations, written by the stimulus before each start
  logic [63:0] exp_req_addr;
  logic [63:0] exp_ea0;
  logic [4:0]  op_k;
  int          exp_idx;
  int          n_writes, n_reqs;
  logic        op_finished;

  // memory model and port monitor state
  logic [15:0] lfsr = 16'hACE1;
  logic        req_fire_pend = 1'b0, rsp_fire_pend = 1'b0;
  logic        outstanding = 1'b0, pending_rsp = 1'b0;
  logic [63:0] pend_addr;
  int          rsp_delay;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_addr;
  logic        wrote_last = 1'b0, saw_done = 1'b0;
  int          cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      // R10: one cycle after done the block is idle and done is gone
      if (saw_done) begin
        chk(!busy && !done, "R10 idle after done", {62'd0, busy, done}, 64'd0);
        saw_done = 1'b0;
      end
      if (wrote_last) begin
        chk(done == 1'b1, "R10 done after last write", {63'd0, done}, 64'd1);
        chk(n_writes == 32 - int'(op_k), "R4/R9 write count",
            64'(n_writes), 64'(32 - int'(op_k)));
        chk(n_reqs == 32 - int'(op_k), "R9 request count",
            64'(n_reqs), 64'(32 - int'(op_k)));
        wrote_last = 1'b0;
        saw_done = 1'b1;
        op_finished = 1'b1;
      end else if (done) begin
        chk(1'b0, "R10 unexpected done", 64'd1, 64'd0);
      end
      // R11: write follows the response handshake by one cycle
      if (rsp_fire_pend) begin
        mem_rsp_valid = 1'b0;
        rsp_fire_pend = 1'b0;
        chk(rf_we == 1'b1, "R11 write after response", {63'd0, rf_we}, 64'd1);
      end
      if (req_fire_pend) begin
        req_fire_pend = 1'b0;
        pending_rsp = 1'b1;
        rsp_delay = int'(lfsr[2:1]);
      end
      if (rf_we) begin
        chk(int'(rf_idx) == exp_idx, "R4 write index", 64'(rf_idx), 64'(exp_idx));
        chk(rf_data == {32'd0, mem_word(exp_ea0 + 64'(4 * (exp_idx - int'(op_k))))},
            "R5 write data", rf_data,
            {32'd0, mem_word(exp_ea0 + 64'(4 * (exp_idx - int'(op_k))))});
        n_writes++;
        if (rf_idx == 5'd31) wrote_last = 1'b1;
        exp_idx++;
        outstanding = 1'b0;
      end
      if (outstanding && mem_req_valid)
        chk(1'b0, "R6 second request in flight", 64'd1, 64'd0);
      if (mem_rsp_ready && !outstanding)
        chk(1'b0, "R11 response ready while idle", 64'd1, 64'd0);
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R7 request held",
            mem_req_addr, prev_addr);
      // memory response side
      if (pending_rsp) begin
        if (rsp_delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_word(pend_addr);
          pending_rsp = 1'b0;
        end else begin
          rsp_delay--;
        end
      end
      mem_req_ready = lfsr[0] | lfsr[3];
      if (mem_req_valid && mem_req_ready) begin
        chk(mem_req_addr == exp_req_addr, "R2/R3 request address",
            mem_req_addr, exp_req_addr);
        pend_addr = mem_req_addr;
        exp_req_addr = exp_req_addr + 64'd4;
        n_reqs++;
        req_fire_pend = 1'b1;
        outstanding = 1'b1;
      end
      if (mem_rsp_valid && mem_rsp_ready) rsp_fire_pend = 1'b1;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
    end
  end

  task automatic run_op(input logic [4:0] k, input logic [4:0] bi,
                        input logic [63:0] bv, input logic [15:0] d,
                        input logic interfere);
    @(negedge clk);
    exp_ea0 = ((bi == 5'd0) ? 64'd0 : bv) + {{48{d[15]}}, d};
    exp_req_addr = exp_ea0;
    op_k = k;
    exp_idx = int'(k);
    n_writes = 0;
    n_reqs = 0;
    op_finished = 1'b0;
    start_idx = k;
    base_idx = bi;
    base_val = bv;
    disp = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", {63'd0, busy}, 64'd1);
    if (interfere) begin
      repeat (3) @(negedge clk);
      // R8: a start while busy with other operands must change nothing
      start_idx = 5'd0;
      base_idx = 5'd7;
      base_val = 64'h1234_0000;
      disp = 16'h0100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy during sequence", {63'd0, busy}, 64'd1);
    end
    while (!op_finished) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_req_valid && !mem_rsp_ready && !rf_we,
        "R1 reset idle", {59'd0, busy, done, mem_req_valid, mem_rsp_ready, rf_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {62'd0, busy, done}, 64'd0);
    // R9: single-word run
    run_op(5'd31, 5'd3, 64'h0000_0000_0001_0000, 16'h0010, 1'b0);
    // full sweep of starting indices under three base/displacement cases
    for (int k = 0; k < 32; k++) begin
      run_op(5'(k), 5'd5, 64'h0000_00AB_0000_1000, 16'h0040, 1'b0);
      // R2: base register number 0 reads as zero, negative displacement
      run_op(5'(k), 5'd0, 64'hFFFF_0000_DEAD_0000, 16'hFF00, (k % 4) == 1);
      run_op(5'(k), 5'd9, 64'h7FFF_FFFF_FFFF_FFF0, 16'h8004, (k % 5) == 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule